// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator

This block produces one pulse train from an incrementing cycle counter. Each period opens with a high interval of `width` cycles and closes with a low interval that lasts for the rest of the period. The period, the width and a phase offset are all counted in cycles of the channel clock. Each setting has two copies. Software writes the staging copy at any time. The live copy that drives the counter changes only when a load request is seen. The live offset is passed out to a shared offset counter outside this block.

The channel starts, or realigns, on a one-cycle trigger from an alignment controller. Two mode inputs choose how a trigger is handled. With `start_now` high, the first high interval begins on the cycle right after the trigger. With it low, the channel first stays low for one full programmed period. With `force_realign` high, a trigger cuts off the running period at once. With it low, the running period completes first. A run-enable input releases the channel from the software-held reset, and the channel makes no pulses while that input is low.

Top module: `pwm_channel`

## Requirements
- R1: After a trigger taken while idle with `start_now`=1, `pwm_o` is high for the first `width` cycles and low for the remaining `period-width` cycles of every period. The first high cycle is the cycle right after the clock edge that sampled the trigger.
- R2: While the live period is 0, the channel is disabled: `pwm_o` and `eop_o` stay low and triggers have no effect.
- R3: If the live width is greater than or equal to the live period, `pwm_o` is high for the whole period. A live width of 0 keeps `pwm_o` low while `eop_o` still strobes.
- R4: Writing the staging registers (`cfg_we`) without a load does not change the live period, width or offset.
- R5: A one-cycle `load_req` copies the staging period, width and offset into the live set on that clock edge. The live offset then appears on `offset_o`.
- R6: With `force_realign`=1, a trigger taken mid-period restarts the period counter at 0 on the next cycle.
- R7: With `force_realign`=0, a trigger taken mid-period lets the running period finish unchanged. The start sequence selected by `start_now` then begins on the cycle after the period's last cycle.
- R8: With `start_now`=0, after a trigger the output stays low for exactly `period` cycles before the first high interval begins.
- R9: While `run_en` is 0, `pwm_o` and `eop_o` are low and the channel returns to idle. After `run_en` returns to 1, no pulse appears until a new trigger.
- R10: The counter runs from 0 to `period-1` and then wraps to 0. `eop_o` is high exactly in the last cycle (count `period-1`) of each running period.
- R11: After a synchronous reset, `pwm_o`, `eop_o` and `offset_o` are 0, and the live settings are 0, so the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Software release; 0 holds the channel idle |
| cfg_we | input | 1 | Write strobe for the staging registers |
| cfg_period | input | CNT_W | Staging period in cycles |
| cfg_width | input | CNT_W | Staging high time in cycles |
| cfg_offset | input | CNT_W | Staging phase offset in cycles |
| load_req | input | 1 | Copy staging settings to the live set |
| trig | input | 1 | Start / realign trigger, one cycle |
| force_realign | input | 1 | 1: trigger cuts the running period |
| start_now | input | 1 | 1: pulses begin at the trigger; 0: after one period |
| pwm_o | output | 1 | Registered PWM output |
| eop_o | output | 1 | Registered end-of-period strobe |
| offset_o | output | CNT_W | Live offset for the shared offset counter |

## Verification
The hardest case to reach is a trigger that arrives mid-period without forced realignment. In that case the channel must keep a pending flag across the rest of the period, then pass through a full low delay before the pulses start again. The stimulus starts the channel, lets it run a few cycles, clears `force_realign` and `start_now`, and pulses the trigger. It then checks the tail of the interrupted period, the delay period and the periods after it cycle by cycle. The forced case is driven the same way, and the bench checks that the period restarts at count 0 on the very next cycle.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_DELAY = 2'd2
  } ch_state_e;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_width,
  input  logic [CNT_W-1:0] cfg_offset,
  input  logic             load_req,
  output logic [CNT_W-1:0] act_period,
  output logic [CNT_W-1:0] act_width,
  output logic [CNT_W-1:0] act_offset
);
  logic [CNT_W-1:0] stg_period, stg_width, stg_offset;

  // Staging copy: written freely by software
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_period <= '0;
      stg_width  <= '0;
      stg_offset <= '0;
    end else if (cfg_we) begin
      stg_period <= cfg_period;
      stg_width  <= cfg_width;
      stg_offset <= cfg_offset;
    end
  end

  // Live copy: changes only on a load request
  always_ff @(posedge clk) begin
    if (rst) begin
      act_period <= '0;
      act_width  <= '0;
      act_offset <= '0;
    end else if (load_req) begin
      act_period <= stg_period;
      act_width  <= stg_width;
      act_offset <= stg_offset;
    end
  end

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_req |=> ($stable(act_period) && $stable(act_width) && $stable(act_offset))); // R4
endmodule

// File: rtl/pwm_seq.sv
module pwm_seq
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             trig,
  input  logic             force_realign,
  input  logic             start_now,
  input  logic [CNT_W-1:0] period,
  output ch_state_e        nxt_state,
  output logic [CNT_W-1:0] nxt_cnt
);
  ch_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, nxt_pend;
  ch_state_e        start_state;
  logic             at_last;

  assign start_state = start_now ? CH_RUN : CH_DELAY;
  assign at_last     = (cnt_q >= period - 1'b1);

  always_comb begin
    nxt_state = state_q;
    nxt_cnt   = cnt_q;
    nxt_pend  = pend_q;
    if (!en || period == '0) begin
      nxt_state = CH_IDLE;
      nxt_cnt   = '0;
      nxt_pend  = 1'b0;
    end else begin
      unique case (state_q)
        CH_IDLE: begin
          if (trig) begin
            nxt_state = start_state;
            nxt_cnt   = '0;
          end
        end
        CH_RUN: begin
          if (trig && force_realign) begin
            nxt_state = start_state;
            nxt_cnt   = '0;
            nxt_pend  = 1'b0;
          end else if (at_last) begin
            nxt_state = (pend_q || trig) ? start_state : CH_RUN;
            nxt_cnt   = '0;
            nxt_pend  = 1'b0;
          end else begin
            nxt_cnt  = cnt_q + 1'b1;
            nxt_pend = pend_q | trig;
          end
        end
        CH_DELAY: begin
          if (trig && force_realign) begin
            nxt_state = start_state;
            nxt_cnt   = '0;
          end else if (at_last) begin
            nxt_state = CH_RUN;
            nxt_cnt   = '0;
          end else begin
            nxt_cnt = cnt_q + 1'b1;
          end
        end
        default: begin
          nxt_state = CH_IDLE;
          nxt_cnt   = '0;
          nxt_pend  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= nxt_state;
      cnt_q   <= nxt_cnt;
      pend_q  <= nxt_pend;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (state_q == CH_RUN && en && period != '0 && cnt_q < period - 1'b1 &&
     !(trig && force_realign)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R10
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> (state_q == CH_IDLE)); // R9
endmodule

// File: rtl/pwm_shaper.sv
module pwm_shaper
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ch_state_e        nxt_state,
  input  logic [CNT_W-1:0] nxt_cnt,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] width,
  output logic             pwm_q,
  output logic             eop_q
);
  logic running;
  assign running = (nxt_state == CH_RUN) && (period != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= 1'b0;
      eop_q <= 1'b0;
    end else begin
      pwm_q <= running && (nxt_cnt < width);
      eop_q <= running && (nxt_cnt == period - 1'b1);
    end
  end

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    (period == '0) |=> (!pwm_q && !eop_q)); // R2
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_width,
  input  logic [CNT_W-1:0] cfg_offset,
  input  logic             load_req,
  input  logic             trig,
  input  logic             force_realign,
  input  logic             start_now,
  output logic             pwm_o,
  output logic             eop_o,
  output logic [CNT_W-1:0] offset_o
);
  logic [CNT_W-1:0] act_period, act_width;
  ch_state_e        nxt_state;
  logic [CNT_W-1:0] nxt_cnt;

  pwm_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we),
    .cfg_period(cfg_period), .cfg_width(cfg_width), .cfg_offset(cfg_offset),
    .load_req(load_req),
    .act_period(act_period), .act_width(act_width), .act_offset(offset_o)
  );

  pwm_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .en(run_en), .trig(trig),
    .force_realign(force_realign), .start_now(start_now),
    .period(act_period), .nxt_state(nxt_state), .nxt_cnt(nxt_cnt)
  );

  pwm_shaper #(.CNT_W(CNT_W)) u_shape (
    .clk(clk), .rst(rst), .nxt_state(nxt_state), .nxt_cnt(nxt_cnt),
    .period(act_period), .width(act_width), .pwm_q(pwm_o), .eop_q(eop_o)
  );

  AST_RUN_GATE: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!pwm_o && !eop_o)); // R9
  AST_EOP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (eop_o && act_period > 1 && $stable(act_period)) |=> !eop_o); // R10
endmodule

// File: tb/sim_pwm_channel.sv
module sim_pwm_channel;
  localparam int CLK_P = 10;
  localparam int W     = 16;

  logic         clk = 0, rst = 1, run_en = 0, cfg_we = 0, load_req = 0;
  logic         trig = 0, force_realign = 1, start_now = 1;
  logic [W-1:0] cfg_period = 0, cfg_width = 0, cfg_offset = 0;
  logic         pwm_o, eop_o;
  logic [W-1:0] offset_o;
  int checks = 0, errors = 0;
  bit done = 0;

  pwm_channel #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .cfg_we(cfg_we),
    .cfg_period(cfg_period), .cfg_width(cfg_width), .cfg_offset(cfg_offset),
    .load_req(load_req), .trig(trig), .force_realign(force_realign),
    .start_now(start_now), .pwm_o(pwm_o), .eop_o(eop_o), .offset_o(offset_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Compare n cycles; step v=s+ph; low while v<lead, then periodic pattern
  task automatic check_win(input string req, input int n, input int ph,
                           input int lead, input int p, input int w);
    int bad = 0; int bs = 0; logic [1:0] ba = 0, be = 0;
    for (int s = 0; s < n; s++) begin
      int v = s + ph;
      logic ep, ee;
      if (v < lead) begin ep = 0; ee = 0; end
      else begin
        int q = (v - lead) % p;
        ep = (q < w); ee = (q == p - 1);
      end
      if ({pwm_o, eop_o} !== {ep, ee} && bad == 0) begin
        bad = 1; bs = s; ba = {pwm_o, eop_o}; be = {ep, ee};
      end
      @(negedge clk);
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: step %0d {pwm,eop} actual %b expected %b", req, bs, ba, be);
    end
  endtask

  task automatic pulse_trig();
    trig = 1; @(negedge clk); trig = 0;
  endtask

  task automatic make_idle();
    run_en = 0; @(negedge clk); run_en = 1; @(negedge clk);
  endtask

  task automatic stage(input int p, input int w, input int o, input bit ld);
    cfg_period = p; cfg_width = w; cfg_offset = o; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
    if (ld) begin load_req = 1; @(negedge clk); load_req = 0; end
  endtask

  task automatic t_reset();
    chk("R11 pwm", pwm_o, 0); chk("R11 eop", eop_o, 0); chk("R11 offset", offset_o, 0);
    pulse_trig();
    check_win("R11 no pulses after reset", 20, 0, 1000, 10, 4);
  endtask

  task automatic t_basic();
    stage(10, 4, 3, 1);
    chk("R5 offset", offset_o, 3);
    force_realign = 1; start_now = 1; make_idle(); pulse_trig();
    check_win("R1/R10 basic 10/4", 35, 0, 0, 10, 4);
    stage(7, 1, 3, 1); make_idle(); pulse_trig();
    check_win("R1/R10 basic 7/1", 30, 0, 0, 7, 1);
  endtask

  task automatic t_extremes();
    stage(5, 5, 0, 1); make_idle(); pulse_trig();
    check_win("R3 width==period", 15, 0, 0, 5, 5);
    stage(5, 9, 0, 1); make_idle(); pulse_trig();
    check_win("R3 width>period", 15, 0, 0, 5, 9);
    stage(5, 0, 0, 1); make_idle(); pulse_trig();
    check_win("R3 width 0", 15, 0, 0, 5, 0);
    stage(1, 1, 0, 1); make_idle(); pulse_trig();
    check_win("R10 period 1", 8, 0, 0, 1, 1);
  endtask

  task automatic t_disable();
    stage(0, 4, 0, 1); make_idle(); pulse_trig();
    check_win("R2 period 0", 30, 0, 1000, 10, 4);
  endtask

  task automatic t_shadow();
    stage(10, 4, 2, 1);
    stage(6, 2, 9, 0);
    chk("R4 offset unchanged", offset_o, 2);
    make_idle(); pulse_trig();
    check_win("R4 staging ignored", 30, 0, 0, 10, 4);
    load_req = 1; @(negedge clk); load_req = 0;
    chk("R5 offset loaded", offset_o, 9);
    make_idle(); pulse_trig();
    check_win("R5 new settings", 24, 0, 0, 6, 2);
  endtask

  task automatic t_force();
    stage(10, 4, 0, 1); force_realign = 1; start_now = 1;
    make_idle(); pulse_trig();
    check_win("R6 pre", 6, 0, 0, 10, 4);
    pulse_trig();
    check_win("R6 forced restart", 30, 0, 0, 10, 4);
  endtask

  task automatic t_soft();
    stage(10, 4, 0, 1); force_realign = 1; start_now = 1;
    make_idle(); pulse_trig();
    check_win("R7 pre", 4, 0, 0, 10, 4);
    force_realign = 0; start_now = 0;
    pulse_trig();
    check_win("R7 period finishes", 5, 5, 0, 10, 4);
    check_win("R7/R8 delayed restart", 30, 0, 10, 10, 4);
    force_realign = 1;
  endtask

  task automatic t_delay();
    stage(8, 3, 0, 1); force_realign = 1; start_now = 0;
    make_idle(); pulse_trig();
    check_win("R8 one period delay", 32, 0, 8, 8, 3);
    start_now = 1;
  endtask

  task automatic t_run_en();
    stage(10, 4, 0, 1); make_idle(); pulse_trig();
    check_win("R9 pre", 3, 0, 0, 10, 4);
    run_en = 0; @(negedge clk);
    check_win("R9 held low", 6, 0, 1000, 10, 4);
    run_en = 1; @(negedge clk);
    check_win("R9 no restart without trigger", 20, 0, 1000, 10, 4);
    pulse_trig();
    check_win("R9 restart", 20, 0, 0, 10, 4);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; run_en = 1; @(negedge clk);
    t_reset();
    t_basic();
    t_extremes();
    t_disable();
    t_shadow();
    t_force();
    t_soft();
    t_delay();
    t_run_en();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule